// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous fast-page-mode DRAM alive. After reset it holds every strobe inactive for a programmable power-up pause. It then runs a fixed number of warm-up refresh cycles on its own. The bus grant is ignored during warm-up. Only after the last warm-up cycle does it raise `init_done`, which tells the access controller that normal traffic may start.

From then on, an interval divider marks one refresh as owed every `INTERVAL_CYC` clocks. Owed refreshes are counted, and the count saturates at `MAX_PEND`. While any refresh is owed, the block raises `req`. Once `grant` is seen, it drives the strobes for one cycle per owed refresh, back to back, and then drops `req`.

Each cycle is one of two kinds, chosen by `row_mode`. The mode is sampled when the cycle starts.
- A CAS-before-RAS cycle pulls both column strobes low ahead of the row strobe, with write-enable held high. The DRAM supplies the row itself.
- A row-addressed cycle keeps both column strobes high and drives the row from an internal counter. The counter advances after each such cycle.

The FSM states and transitions are:
- `ST_PAUSE` goes to `ST_SETUP` when the pause ends.
- `ST_SETUP` goes to `ST_STROBE` after `T_SU` cycles.
- `ST_STROBE` goes to `ST_PRECH` after `T_RAS` cycles.
- At the end of `ST_PRECH`, the next state is:
  - during warm-up, `ST_SETUP` for the next warm-up cycle, or `ST_IDLE` after the last one;
  - after warm-up, `ST_REQ` if more refreshes are owed, else `ST_IDLE`.
- `ST_IDLE` goes to `ST_REQ` when a refresh is owed.
- `ST_REQ` goes to `ST_SETUP` on grant.

Top module: `rfsh_seq`

## Requirements
- R1: From reset, `ras_n`=1, `cas_n`=2'b11, `we_n`=1, `req`=0 and `init_done`=0. The first `ras_n` fall comes exactly `PAUSE_CYC`+`T_SU` cycles after reset is released.
- R2: Exactly `WARMUP` refresh cycles run with `grant` low. Their `ras_n` falls are `T_SU`+`T_RAS`+`T_RP` cycles apart. `init_done` rises in cycle `PAUSE_CYC`+`WARMUP`*(`T_SU`+`T_RAS`+`T_RP`) and never falls before the next reset.
- R3: In a CAS-before-RAS cycle, `cas_n` is 2'b00 (bit 1 upper byte, bit 0 lower byte) for exactly `T_SU` cycles before `ras_n` falls. `we_n` is 1 whenever `ras_n` is low.
- R4: In a row-addressed cycle, `cas_n` stays 2'b11 and `addr` equals the row counter, stable across the `ras_n` fall. The counter starts at 0, advances by one per row-addressed cycle, and wraps modulo 2^`ROW_W`.
- R5: Every `ras_n` low pulse lasts exactly `T_RAS` cycles. Between pulses, `ras_n` stays high for at least `T_RP` cycles.
- R6: After `init_done`, one refresh is owed every `INTERVAL_CYC` cycles. `req` first rises `INTERVAL_CYC`+1 cycles after `init_done`. `ras_n` never falls while `grant` is low. With `grant` held high, successive falls are exactly `INTERVAL_CYC` apart.
- R7: Owed refreshes saturate at `MAX_PEND`. When `grant` arrives, exactly that many cycles run, `T_SU`+`T_RAS`+`T_RP`+1 cycles apart, and `req` then drops.
- R8: `row_mode` is sampled when a cycle enters setup. Changing it while `ras_n` is low leaves the running cycle's `cas_n` unchanged.
- R9: CAS-before-RAS cycles leave the row counter untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_mode | input | 1 | 1 = row-addressed refresh, 0 = CAS-before-RAS |
| grant | input | 1 | Bus granted by the access controller |
| req | output | 1 | Refresh wants or holds the bus |
| init_done | output | 1 | Power-up sequence complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Column strobes {upper, lower}, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ROW_W | Row address for row-addressed refresh |

## Verification
The bench times the first strobe against the pause length and counts the warm-up cycles with `grant` held low. A design that miscounts either would open the memory early, or would run seven or nine warm-up cycles. It starves the grant for several intervals and then counts the burst. A counter that wraps instead of saturating gives too few cycles, and one that drops the tick arriving with a completion gives an off-by-one. It flips the refresh mode while the row strobe is low, and sweeps row-addressed cycles past the counter wrap. A design that samples the mode live would release the column strobes mid-pulse, and a CAS-before-RAS cycle that advanced the row would show up as a skipped address.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_REQ,
        ST_SETUP,
        ST_STROBE,
        ST_PRECH
    } rfsh_state_e;
endpackage

// File: rtl/rfsh_divider.sv
module rfsh_divider #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (!en || cnt == LAST) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
    parameter int MAX = 4,
    parameter int W   = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         nz
);
    localparam logic [W-1:0] TOP = W'(MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (cnt != TOP) cnt <= cnt + 1'b1;
                2'b01:   if (cnt != '0)  cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign nz = (cnt != '0);
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] row
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   row <= '0;
        else if (adv) row <= row + 1'b1;
    end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
    import rfsh_pkg::*;
#(
    parameter int ROW_W        = 12,
    parameter int PAUSE_CYC    = 20000,
    parameter int INTERVAL_CYC = 1560,
    parameter int WARMUP       = 8,
    parameter int MAX_PEND     = 4,
    parameter int T_SU         = 1,
    parameter int T_RAS        = 6,
    parameter int T_RP         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_mode,
    input  logic             grant,
    output logic             req,
    output logic             init_done,
    output logic             ras_n,
    output logic [1:0]       cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] addr
);
    localparam int PH_MAX = (T_RAS > T_RP) ? ((T_RAS > T_SU) ? T_RAS : T_SU)
                                           : ((T_RP > T_SU) ? T_RP : T_SU);
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int WU_W   = $clog2(WARMUP + 1);
    localparam int PEND_W = $clog2(MAX_PEND + 1);
    localparam logic [PH_W-1:0]   PH_SU  = PH_W'(T_SU - 1);
    localparam logic [PH_W-1:0]   PH_RAS = PH_W'(T_RAS - 1);
    localparam logic [PH_W-1:0]   PH_RP  = PH_W'(T_RP - 1);
    localparam logic [WU_W-1:0]   WU_END = WU_W'(WARMUP - 1);
    localparam logic [PEND_W-1:0] ONE    = PEND_W'(1);

    rfsh_state_e       state, state_nx;
    logic [PH_W-1:0]   phase;
    logic [WU_W-1:0]   wu_cnt;
    logic              init_q;
    logic              cyc_row;
    logic              pause_tick, iv_tick;
    logic [PEND_W-1:0] pend_cnt;
    logic              pend_nz;
    logic [ROW_W-1:0]  row;
    logic              done, row_adv, grant_eff, more;

    assign done      = (state == ST_PRECH) && (phase == PH_RP);
    assign row_adv   = (state == ST_STROBE) && (phase == PH_RAS) && cyc_row;
    assign grant_eff = grant || !init_q;
    assign more      = (pend_cnt > ONE) || iv_tick;

    rfsh_divider #(.LIMIT(PAUSE_CYC)) u_pause (
        .clk(clk), .rst_n(rst_n), .en(state == ST_PAUSE), .tick(pause_tick)
    );

    rfsh_divider #(.LIMIT(INTERVAL_CYC)) u_interval (
        .clk(clk), .rst_n(rst_n), .en(init_q), .tick(iv_tick)
    );

    rfsh_pending #(.MAX(MAX_PEND), .W(PEND_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .inc(iv_tick), .dec(done && init_q),
        .cnt(pend_cnt), .nz(pend_nz)
    );

    rfsh_row_ctr #(.W(ROW_W)) u_row (
        .clk(clk), .rst_n(rst_n), .adv(row_adv), .row(row)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PAUSE:  if (pause_tick)      state_nx = ST_SETUP;
            ST_IDLE:   if (pend_nz)         state_nx = ST_REQ;
            ST_REQ:    if (grant_eff)       state_nx = ST_SETUP;
            ST_SETUP:  if (phase == PH_SU)  state_nx = ST_STROBE;
            ST_STROBE: if (phase == PH_RAS) state_nx = ST_PRECH;
            ST_PRECH: begin
                if (done) begin
                    if (!init_q) state_nx = (wu_cnt == WU_END) ? ST_IDLE : ST_SETUP;
                    else         state_nx = more ? ST_REQ : ST_IDLE;
                end
            end
            default:                        state_nx = ST_PAUSE;
        endcase
    end

    // state register and per-cycle bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_PAUSE;
            phase   <= '0;
            wu_cnt  <= '0;
            init_q  <= 1'b0;
            cyc_row <= 1'b0;
        end else begin
            state <= state_nx;
            phase <= (state_nx != state) ? '0 : phase + 1'b1;
            if (state_nx == ST_SETUP && state != ST_SETUP) cyc_row <= row_mode;
            if (done && !init_q) begin
                wu_cnt <= wu_cnt + 1'b1;
                if (wu_cnt == WU_END) init_q <= 1'b1;
            end
        end
    end

    // strobe outputs
    always_comb begin
        req   = 1'b0;
        ras_n = 1'b1;
        cas_n = 2'b11;
        addr  = '0;
        unique case (state)
            ST_REQ, ST_PRECH: req = 1'b1;
            ST_SETUP, ST_STROBE: begin
                req   = 1'b1;
                ras_n = (state != ST_STROBE);
                if (cyc_row) addr  = row;
                else         cas_n = 2'b00;
            end
            default: ;
        endcase
    end

    assign we_n      = 1'b1;
    assign init_done = init_q;
endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk #(
    parameter int ROW_W    = 12,
    parameter int MAX_PEND = 4,
    parameter int PEND_W   = 3,
    parameter int T_RAS    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ras_n,
    input logic [1:0]        cas_n,
    input logic              we_n,
    input logic [ROW_W-1:0]  addr,
    input logic              init_done,
    input logic [PEND_W-1:0] pend_cnt
);
    logic [15:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      low_cnt <= '0;
        else if (!ras_n) low_cnt <= low_cnt + 1'b1;
        else             low_cnt <= '0;
    end

    p_init_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_we_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> we_n);

    p_cas_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && cas_n != 2'b11) |-> ($past(cas_n) == cas_n));

    p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(addr));

    p_ras_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_cnt == 16'(T_RAS)));

    p_pend_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= PEND_W'(MAX_PEND));

    p_cas_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n)) |-> $stable(cas_n));
endmodule

bind rfsh_seq rfsh_seq_chk #(
    .ROW_W(ROW_W), .MAX_PEND(MAX_PEND), .PEND_W(PEND_W), .T_RAS(T_RAS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .init_done(init_done), .pend_cnt(pend_cnt)
);

// File: tb/rfsh_seq_tb.sv
module rfsh_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W      = 4;
    localparam int PAUSE      = 30;
    localparam int IVL        = 40;
    localparam int WARM       = 8;
    localparam int MAXP       = 3;
    localparam int TSU        = 2;
    localparam int TRAS       = 3;
    localparam int TRP        = 2;
    localparam int CYC_LEN    = TSU + TRAS + TRP;

    logic clk = 1'b0, rst_n = 1'b0, row_mode = 1'b1, grant = 1'b0;
    logic req, init_done, ras_n, we_n;
    logic [1:0] cas_n;
    logic [ROW_W-1:0] addr;

    int errors = 0, checks = 0, cyc = 0;
    bit ended = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfsh_seq #(
        .ROW_W(ROW_W), .PAUSE_CYC(PAUSE), .INTERVAL_CYC(IVL), .WARMUP(WARM),
        .MAX_PEND(MAXP), .T_SU(TSU), .T_RAS(TRAS), .T_RP(TRP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .row_mode(row_mode), .grant(grant),
        .req(req), .init_done(init_done), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .addr(addr)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // strobe monitor
    int fall_t[$];
    int n_cbr = 0, exp_row = 0, low_len = 0, pre_len = 0, cas_lead = 0;
    bit prev_ras = 1'b1, have_rise = 1'b0, cas_ok = 1'b1;
    logic [1:0] cas_held = 2'b11;

    always @(negedge clk) if (rst_n) begin
        if (prev_ras && !ras_n) begin
            chk(we_n == 1'b1, "R3 we_n high at RAS fall", int'(we_n), 1);
            if (init_done) chk(grant == 1'b1, "R6 RAS fall only with grant", int'(grant), 1);
            if (have_rise) chk(pre_len >= TRP, "R5 precharge length", pre_len, TRP);
            if (cas_n != 2'b11) begin
                chk(cas_n == 2'b00, "R3 both CAS low", int'(cas_n), 0);
                chk(cas_lead == TSU, "R3 CAS lead before RAS", cas_lead, TSU);
                n_cbr++;
            end else begin
                chk(int'(addr) == exp_row, "R4 R9 row address", int'(addr), exp_row);
                exp_row = (exp_row + 1) % (1 << ROW_W);
            end
            fall_t.push_back(cyc);
            low_len = 1;
            cas_held = cas_n;
            cas_ok = 1'b1;
        end else if (!ras_n) begin
            low_len++;
            if (cas_n != cas_held) cas_ok = 1'b0;
        end
        if (!prev_ras && ras_n) begin
            chk(low_len == TRAS, "R5 RAS low width", low_len, TRAS);
            chk(cas_ok, "R8 CAS unchanged during RAS low", int'(cas_ok), 1);
            have_rise = 1'b1;
            pre_len = 1;
        end else if (ras_n) begin
            pre_len++;
        end
        cas_lead = (ras_n && cas_n == 2'b00) ? cas_lead + 1 : 0;
        prev_ras = ras_n;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int t0, nb, cb;
        repeat (3) @(posedge clk);
        step();
        chk(ras_n == 1'b1 && cas_n == 2'b11 && we_n == 1'b1, "R1 strobes idle in reset",
            int'({ras_n, cas_n, we_n}), 15);
        chk(req == 1'b0 && init_done == 1'b0, "R1 req/init low in reset",
            int'({req, init_done}), 0);
        rst_n = 1'b1;

        // power-up pause and warm-up, grant held low
        while (!init_done) step();
        t0 = cyc;
        chk(fall_t.size() == WARM, "R2 warm-up cycle count", fall_t.size(), WARM);
        if (fall_t.size() > 0)
            chk(fall_t[0] == PAUSE + TSU, "R1 first RAS fall", fall_t[0], PAUSE + TSU);
        for (int i = 1; i < fall_t.size(); i++)
            chk(fall_t[i] - fall_t[i-1] == CYC_LEN, "R2 warm-up spacing",
                fall_t[i] - fall_t[i-1], CYC_LEN);
        chk(t0 == PAUSE + WARM * CYC_LEN, "R2 init_done timing", t0, PAUSE + WARM * CYC_LEN);
        chk(req == 1'b0, "R6 req low after warm-up", int'(req), 0);

        // starved grant: pending saturates
        row_mode = 1'b0;
        while (!req) step();
        chk(cyc == t0 + IVL + 1, "R6 first request timing", cyc, t0 + IVL + 1);
        while (cyc < t0 + 5 * IVL + 5) step();
        chk(fall_t.size() == WARM, "R6 no refresh without grant", fall_t.size(), WARM);
        chk(req == 1'b1, "R6 req held while waiting", int'(req), 1);
        nb = fall_t.size();
        cb = n_cbr;
        grant = 1'b1;
        repeat (30) step();
        chk(fall_t.size() - nb == MAXP, "R7 burst length", fall_t.size() - nb, MAXP);
        chk(n_cbr - cb == MAXP, "R3 burst uses CAS-before-RAS", n_cbr - cb, MAXP);
        chk(req == 1'b0, "R7 req drops after burst", int'(req), 0);
        for (int i = nb + 1; i < fall_t.size(); i++)
            chk(fall_t[i] - fall_t[i-1] == CYC_LEN + 1, "R7 burst spacing",
                fall_t[i] - fall_t[i-1], CYC_LEN + 1);

        // mode flip while RAS is low
        nb = fall_t.size();
        cb = n_cbr;
        while (fall_t.size() == nb) step();
        row_mode = 1'b1;
        chk(n_cbr == cb + 1, "R8 running cycle stays CAS-before-RAS", n_cbr - cb, 1);
        while (fall_t.size() == nb + 1) step();
        chk(n_cbr == cb + 1, "R8 next cycle is row-addressed", n_cbr - cb, 1);
        chk(exp_row == WARM + 1, "R9 row counter after CBR cycles", exp_row, WARM + 1);
        chk(fall_t[nb+1] - fall_t[nb] == IVL, "R6 steady interval", fall_t[nb+1] - fall_t[nb], IVL);

        // row-addressed sweep past the counter wrap
        nb = fall_t.size();
        repeat (20 * IVL - 5) step();
        chk(fall_t.size() - nb == 19, "R6 refreshes in sweep", fall_t.size() - nb, 19);
        for (int i = nb; i < fall_t.size(); i++)
            chk(fall_t[i] - fall_t[i-1] == IVL, "R6 sweep interval",
                fall_t[i] - fall_t[i-1], IVL);
        chk(exp_row == (WARM + 20) % (1 << ROW_W), "R4 row wrap",
            exp_row, (WARM + 20) % (1 << ROW_W));

        finish_run();
    end
endmodule